// File: doc/BRIEF.md
# Flash Command Sequencer with Lock

This block sits on the CPU write path into an on-chip flash region and turns pairs of 16-bit bus writes into commands for a flash array engine. Two commands are recognised. The first is a word program, which writes one data word to one even address. The second is a block lock-bit clear, which protects one block against later programming. Each command takes two bus cycles. The address of the first cycle must match the address of the second, and both cycles must be at even addresses.

When a sequence is valid and allowed, the block sends one start pulse to the engine, together with the operation, address and data. It then stays busy until the engine returns a ready pulse. A sequence is refused in three cases: the rewrite-enable input is low, the main-clock-stopped flag is high, or the target block is locked. A malformed second cycle is also refused. A refused sequence returns the sequencer to idle and sets a sticky error flag.

The block keeps one lock bit for each block of the region. A lock bit reads 1 when the block is unlocked, and the lock command clears it to 0.

Top module: `flash_cmd_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle: `eng_start`, `busy` and `seq_err` are 0, and every bit of `lock_bits` is 1.
- R2: A write to an odd address has no effect in any state. It does not start, advance, abort or clear a sequence, and it does not touch `seq_err`.
- R3: An even write with low byte 0x40 at address A, followed by an even write of data D at the same address A, raises `eng_start` for exactly one cycle. This happens in the cycle after the second write. At the same time `eng_op`=0, `eng_addr`=A and `eng_data`=D.
- R4: In a program sequence, a second-cycle address that differs from the first starts nothing and sets `seq_err`. The sequencer then returns to idle.
- R5: An even write with low byte 0x77 at the uppermost even address T of a block (block offset BLOCK_BYTES-2), followed by a write with low byte 0xD0 at T, starts the engine with `eng_op`=1 and `eng_addr`=T. The same edge clears that block's bit in `lock_bits`. The high data byte is ignored.
- R6: A lock sequence is refused, sets `seq_err` and leaves `lock_bits` unchanged in any of these cases: the address is not a block top, the two addresses differ, or the second low byte is not 0xD0.
- R7: While `clk_stopped` is 1 during the second cycle, neither command starts and `seq_err` is set.
- R8: While `rewrite_en` is 0, even writes are not accepted. Dropping `rewrite_en` while a first cycle is pending returns the sequencer to idle without setting `seq_err`.
- R9: From a start until the cycle after `eng_ready` is seen, `busy` is 1 and every write is ignored. This holds even for a write in the same cycle as `eng_ready`.
- R10: A program aimed at a block whose lock bit is 0 is refused and sets `seq_err`.
- R11: `seq_err` is sticky. It is cleared only by an even write with low byte 0x50 while idle with `rewrite_en` at 1.
- R12: In idle, an even write whose low byte is none of 0x40, 0x77 or 0x50 is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe into the flash region |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 16 | Write data |
| rewrite_en | input | 1 | CPU rewrite mode enabled |
| clk_stopped | input | 1 | Main clock flagged as stopped |
| eng_ready | input | 1 | One-cycle completion pulse from the array engine |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 1 | 0 = word program, 1 = lock-bit clear |
| eng_addr | output | ADDR_W | Target address of the started operation |
| eng_data | output | 16 | Data of the started operation |
| busy | output | 1 | Engine operation in progress |
| seq_err | output | 1 | Sticky sequence-error flag |
| lock_bits | output | 2**(ADDR_W-log2(BLOCK_BYTES)) | Per-block lock bits, 1 = unlocked |

## Verification
Two events can fall in the same cycle: the engine's ready pulse that ends the busy state, and a new CPU write. The bench provokes this by driving `eng_ready` together with a 0x40 write. It then judges the outcome by checking that `busy` has dropped and that a matching second cycle at the same address starts nothing and flags no error. A lock clear and the lock check of a later program are also placed back to back. The bench confirms that the cleared bit is already in effect for the very next program.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [7:0] CODE_PROGRAM = 8'h40;
    localparam logic [7:0] CODE_LOCK    = 8'h77;
    localparam logic [7:0] CODE_CONFIRM = 8'hD0;
    localparam logic [7:0] CODE_CLEAR   = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_LOCK = 2'd2,
        ST_BUSY = 2'd3
    } fcs_state_e;

    typedef enum logic {
        OP_PROGRAM  = 1'b0,
        OP_LOCK_CLR = 1'b1
    } fcs_op_e;

    typedef enum logic [1:0] {
        K_OTHER = 2'd0,
        K_PROG  = 2'd1,
        K_LOCK  = 2'd2,
        K_CLEAR = 2'd3
    } fcs_kind_e;

    // Decoded view of one bus write
    typedef struct packed {
        logic      take;     // strobe at an even address
        fcs_kind_e kind;     // first-cycle class of the low byte
        logic      confirm;  // low byte is the lock confirm code
        logic      at_top;   // address is the uppermost even word of its block
    } fcs_wr_t;

    function automatic fcs_kind_e classify(input logic [7:0] low);
        case (low)
            CODE_PROGRAM: return K_PROG;
            CODE_LOCK:    return K_LOCK;
            CODE_CLEAR:   return K_CLEAR;
            default:      return K_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 12,
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_low,
    output fcs_wr_t           wi,
    output logic [BLK_W-1:0]  blk_idx
);
    localparam logic [OFF_W-1:0] TOP_OFF = {{(OFF_W-1){1'b1}}, 1'b0};

    always_comb begin
        wi.take    = wr_en && !wr_addr[0];
        wi.kind    = classify(wr_low);
        wi.confirm = (wr_low == CODE_CONFIRM);
        wi.at_top  = (wr_addr[OFF_W-1:0] == TOP_OFF);
        blk_idx    = wr_addr[ADDR_W-1:OFF_W];
    end
endmodule

// File: rtl/fcs_lock_reg.sv
module fcs_lock_reg #(
    parameter int NUM_BLK = 16,
    localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_en,
    input  logic [BLK_W-1:0]   idx,
    output logic               unlocked,
    output logic [NUM_BLK-1:0] bits
);
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[b] <= 1'b1;
            else if (clr_en && (idx == BLK_W'(b)))
                bits[b] <= 1'b0;
        end
    end

    assign unlocked = bits[idx];

    // A lock bit is only ever cleared, never set again outside reset
    assert_lock_never_sets_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((bits & ~$past(bits)) == '0));

    // Exactly the addressed bit falls on a clear request
    assert_lock_clear_target_R5: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !bits[$past(idx)]);
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  fcs_wr_t           wi,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              rewrite_en,
    input  logic              clk_stopped,
    input  logic              eng_ready,
    input  logic              blk_unlocked,
    output logic              lock_clr_en,
    output logic              eng_start,
    output logic              eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [15:0]       eng_data,
    output logic              busy,
    output logic              seq_err
);
    fcs_state_e        st_q;
    logic [ADDR_W-1:0] pend_q;
    logic              second, same_addr, prog_ok, lock_ok, clear_req;

    always_comb begin
        second      = rewrite_en && wi.take;
        same_addr   = (wr_addr == pend_q);
        prog_ok     = same_addr && !clk_stopped && blk_unlocked;
        lock_ok     = same_addr && !clk_stopped && wi.at_top && wi.confirm;
        lock_clr_en = (st_q == ST_LOCK) && second && lock_ok;
        clear_req   = (st_q == ST_IDLE) && second && (wi.kind == K_CLEAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pend_q    <= '0;
            eng_start <= 1'b0;
            eng_op    <= OP_PROGRAM;
            eng_addr  <= '0;
            eng_data  <= '0;
            seq_err   <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (second) begin
                        pend_q <= wr_addr;
                        case (wi.kind)
                            K_PROG:  st_q <= ST_PROG;
                            K_LOCK:  st_q <= ST_LOCK;
                            K_CLEAR: seq_err <= 1'b0;
                            default: ;
                        endcase
                    end
                end
                ST_PROG, ST_LOCK: begin
                    if (!rewrite_en) begin
                        st_q <= ST_IDLE;
                    end else if (wi.take) begin
                        if ((st_q == ST_PROG) ? prog_ok : lock_ok) begin
                            st_q      <= ST_BUSY;
                            eng_start <= 1'b1;
                            eng_op    <= (st_q == ST_PROG) ? OP_PROGRAM : OP_LOCK_CLR;
                            eng_addr  <= wr_addr;
                            eng_data  <= wr_data;
                        end else begin
                            st_q    <= ST_IDLE;
                            seq_err <= 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (eng_ready) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (st_q == ST_BUSY);

    assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    assert_start_with_busy_R9: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_ready) |=> busy);

    assert_no_start_clock_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !$past(clk_stopped));

    assert_odd_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_addr[0] && rewrite_en && !eng_ready) |=> (st_q == $past(st_q)));

    assert_error_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_err && !clear_req) |=> seq_err);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BLOCK_BYTES = 4096,
    localparam int OFF_W      = $clog2(BLOCK_BYTES),
    localparam int BLK_W      = ADDR_W - OFF_W,
    localparam int NUM_BLK    = 2 ** BLK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [15:0]        wr_data,
    input  logic               rewrite_en,
    input  logic               clk_stopped,
    input  logic               eng_ready,
    output logic               eng_start,
    output logic               eng_op,
    output logic [ADDR_W-1:0]  eng_addr,
    output logic [15:0]        eng_data,
    output logic               busy,
    output logic               seq_err,
    output logic [NUM_BLK-1:0] lock_bits
);
    fcs_wr_t          wi;
    logic [BLK_W-1:0] blk_idx;
    logic             blk_unlocked;
    logic             lock_clr_en;

    fcs_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_low  (wr_data[7:0]),
        .wi      (wi),
        .blk_idx (blk_idx)
    );

    fcs_lock_reg #(.NUM_BLK(NUM_BLK)) u_locks (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (lock_clr_en),
        .idx      (blk_idx),
        .unlocked (blk_unlocked),
        .bits     (lock_bits)
    );

    fcs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wi           (wi),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rewrite_en   (rewrite_en),
        .clk_stopped  (clk_stopped),
        .eng_ready    (eng_ready),
        .blk_unlocked (blk_unlocked),
        .lock_clr_en  (lock_clr_en),
        .eng_start    (eng_start),
        .eng_op       (eng_op),
        .eng_addr     (eng_addr),
        .eng_data     (eng_data),
        .busy         (busy),
        .seq_err      (seq_err)
    );
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rewrite_en = 1'b1;
    logic        clk_stopped = 1'b0;
    logic        eng_ready = 1'b0;
    logic        eng_start, eng_op, busy, seq_err;
    logic [15:0] eng_addr, eng_data, lock_bits;
    logic [15:0] lock_model = 16'hFFFF;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_cmd_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rewrite_en(rewrite_en), .clk_stopped(clk_stopped), .eng_ready(eng_ready),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr), .eng_data(eng_data),
        .busy(busy), .seq_err(seq_err), .lock_bits(lock_bits)
    );

    typedef struct packed {
        logic [15:0] d1, a1, d2, a2;
        logic        stop, exp_start, exp_op, exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h0040, 16'h1000, 16'hA5A5, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 program
        '{16'h0040, 16'h2000, 16'h1111, 16'h2002, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 mismatch
        '{16'h0077, 16'h3FFE, 16'h00D0, 16'h3FFE, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 lock block 3
        '{16'h0040, 16'h3010, 16'h2222, 16'h3010, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 locked block
        '{16'h0077, 16'h4FFC, 16'h00D0, 16'h4FFC, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 not top
        '{16'h0077, 16'h5FFE, 16'h00D1, 16'h5FFE, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 bad confirm
        '{16'h0040, 16'h6000, 16'h3333, 16'h6000, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 program stopped
        '{16'h0077, 16'h7FFE, 16'h12D0, 16'h7FFE, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 high byte free
        '{16'h0040, 16'hFFFE, 16'hFFFF, 16'hFFFE, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 last word
        '{16'h0077, 16'h8FFE, 16'h00D0, 16'h8FFE, 1'b1, 1'b0, 1'b0, 1'b1}  // R7 lock stopped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write from a falling edge; return at the next falling edge
    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ready_pulse();
        eng_ready = 1'b1;
        @(negedge clk);
        eng_ready = 1'b0;
    endtask

    task automatic clear_status();
        bus_wr(16'h0000, 16'h0050);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 start", eng_start, 0);
        chk("R1 busy", busy, 0);
        chk("R1 err", seq_err, 0);
        chk("R1 locks", lock_bits, 16'hFFFF);

        // Table walk: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            clk_stopped = 1'b0;
            bus_wr(VECS[i].a1, VECS[i].d1);
            clk_stopped = VECS[i].stop;
            bus_wr(VECS[i].a2, VECS[i].d2);
            clk_stopped = 1'b0;
            if (VECS[i].exp_start && VECS[i].exp_op) lock_model[VECS[i].a2[15:12]] = 1'b0;
            chk($sformatf("R3/R5 vec%0d start", i), eng_start, VECS[i].exp_start);
            chk($sformatf("R4/R6/R7/R10 vec%0d err", i), seq_err, VECS[i].exp_err);
            chk($sformatf("R5/R6 vec%0d locks", i), lock_bits, lock_model);
            if (VECS[i].exp_start) begin
                chk($sformatf("R3/R5 vec%0d op", i), eng_op, VECS[i].exp_op);
                chk($sformatf("R3/R5 vec%0d addr", i), eng_addr, VECS[i].a2);
                chk($sformatf("R3 vec%0d data", i), eng_data, VECS[i].d2);
                chk($sformatf("R9 vec%0d busy", i), busy, 1);
                @(negedge clk);
                chk($sformatf("R3 vec%0d pulse width", i), eng_start, 0);
                ready_pulse();
                chk($sformatf("R9 vec%0d idle", i), busy, 0);
            end else begin
                clear_status();
                chk($sformatf("R11 vec%0d cleared", i), seq_err, 0);
            end
        end

        // R10 lock clear in effect for the very next program (block 3 locked)
        bus_wr(16'h3100, 16'h0040);
        bus_wr(16'h3100, 16'h4444);
        chk("R10 next program refused", eng_start, 0);
        chk("R10 error set", seq_err, 1);

        // R11 error stays through unrelated and odd writes
        bus_wr(16'h0000, 16'h1234);
        chk("R11 unrelated keeps err", seq_err, 1);
        bus_wr(16'h0001, 16'h0050);
        chk("R2 odd clear ignored", seq_err, 1);
        rewrite_en = 1'b0;
        bus_wr(16'h0000, 16'h0050);
        chk("R11 clear needs rewrite_en", seq_err, 1);
        rewrite_en = 1'b1;
        clear_status();
        chk("R11 cleared", seq_err, 0);

        // R2 odd writes neither start nor advance
        bus_wr(16'h1001, 16'h0040);
        bus_wr(16'h1001, 16'h5678);
        chk("R2 odd no start", eng_start, 0);
        chk("R2 odd no err", seq_err, 0);
        bus_wr(16'h1000, 16'h0040);
        bus_wr(16'h1001, 16'h9999);
        chk("R2 odd second ignored", eng_start, 0);
        bus_wr(16'h1000, 16'h6789);
        chk("R2 sequence survives odd", eng_start, 1);
        chk("R2 data", eng_data, 16'h6789);
        ready_pulse();

        // R12 unrecognised first byte
        bus_wr(16'h2000, 16'h00AB);
        bus_wr(16'h2000, 16'h00CD);
        chk("R12 no start", eng_start, 0);
        chk("R12 no err", seq_err, 0);

        // R8 rewrite disabled
        rewrite_en = 1'b0;
        bus_wr(16'h1000, 16'h0040);
        bus_wr(16'h1000, 16'h1111);
        chk("R8 disabled no start", eng_start, 0);
        rewrite_en = 1'b1;
        bus_wr(16'h1000, 16'h0040);
        rewrite_en = 1'b0;
        @(negedge clk);
        rewrite_en = 1'b1;
        bus_wr(16'h1000, 16'hAAAA);
        chk("R8 pending dropped", eng_start, 0);
        chk("R8 drop no err", seq_err, 0);

        // R9 writes ignored while busy
        bus_wr(16'h1000, 16'h0040);
        bus_wr(16'h1000, 16'h0101);
        chk("R9 started", busy, 1);
        bus_wr(16'h2FFE, 16'h0077);
        ready_pulse();
        bus_wr(16'h2FFE, 16'h00D0);
        chk("R9 busy write no start", eng_start, 0);
        chk("R9 lock bits kept", lock_bits, lock_model);

        // R9 ready and write in the same cycle
        bus_wr(16'h1000, 16'h0040);
        bus_wr(16'h1000, 16'h0202);
        chk("R9 busy again", busy, 1);
        eng_ready = 1'b1;
        bus_wr(16'h2000, 16'h0040);
        eng_ready = 1'b0;
        chk("R9 ready frees", busy, 0);
        bus_wr(16'h2000, 16'h5555);
        chk("R9 coincident write ignored", eng_start, 0);
        chk("R9 coincident no err", seq_err, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule